// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the device-side end of a three-wire serial link through which an external host loads two on-chip nonvolatile stores: a code store and a separate data store. Serial mode is open only while the programming-hold input is high and the lock input is low. The host sends fixed 32-bit frames: an opcode, an address high byte, an address low byte and a data byte. The block samples SCK and MOSI with its own system clock, which must run at least 40 times faster than SCK.

A programming-enable frame has to be accepted before any other frame takes effect. Writes are self-timed, and each write erases its target location as part of the write, so the host never has to erase first. While a write runs, the host can poll the written location: the byte comes back with its top bit inverted until the write completes. A chip erase sets every location of both stores to FFh. While the erase runs, every read returns 00h. The write and erase durations are parameters counted in system clocks. The two stores are modelled as synchronous RAMs. With the default parameters the stores are 1K and 256 bytes; setting CODE_AW=13 and DATA_AW=11 gives the full 8K and 2K sizes.

Top module: `isp_target`

## Requirements
- R1: After the system reset, `miso` is 0, no write or erase is in progress and the enable state is clear.
- R2: Before an enable frame (opcode A5h) has been accepted, read frames return 00h, and write and erase frames change nothing.
- R3: A write frame (opcode 40h for the code store, 48h for the data store) stores its data byte at address {byte 2, byte 3}, reduced to the store's width, after WRITE_CYCLES clocks. It replaces any earlier value without a prior erase.
- R4: A read frame (opcode 20h for code, 28h for data) returns the stored byte during the fourth byte of the frame, MSB first. MOSI is sampled on each rising SCK edge and MISO changes on each falling SCK edge.
- R5: While a write is in progress, a read of the same store and the same 16-bit address returns the written byte with bit 7 inverted. A read of any other location returns that location's stored value.
- R6: An erase frame (opcode C3h) sets every location of both stores to FFh after ERASE_CYCLES clocks. Any read that completes while the erase is running returns 00h.
- R7: The code and data stores are separate address spaces: the same address in each store holds its own value.
- R8: Write and erase frames that arrive while a write or an erase is in progress are ignored.
- R9: Driving the programming-hold input low clears the enable state and restarts frame alignment, so a new enable frame is needed afterwards.
- R10: While the lock input is high, `miso` stays 0, every frame is ignored and the enable state is cleared.
- R11: Outside the fourth byte of a read frame, `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 40 times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_hold | input | 1 | Programming-mode hold; serial access is open only while this is high |
| lock | input | 1 | Blocks the whole serial interface while high |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data to the host |

## Verification
The main function is exercised with reads of freshly erased locations and with writes followed immediately by polling reads. It is also exercised with an immediate read of a neighbouring location and with completed reads of both stores at the same address. Polling one byte with bit 7 set and one with bit 7 clear shows that exactly bit 7 is inverted and only during the busy window. Frames sent before enable, after the hold input drops, while locked, and during a write or an erase show that each of these gates stops effects without disturbing stored data. A cycle-by-cycle idle check on MISO separates a correctly framed data phase from one that is shifted or extended.

// File: rtl/isp_pkg.sv
package isp_pkg;
    localparam logic [7:0] OPC_ENABLE  = 8'hA5;
    localparam logic [7:0] OPC_ERASE   = 8'hC3;
    localparam logic [7:0] OPC_RD_CODE = 8'h20;
    localparam logic [7:0] OPC_RD_DATA = 8'h28;
    localparam logic [7:0] OPC_WR_CODE = 8'h40;
    localparam logic [7:0] OPC_WR_DATA = 8'h48;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_WRITE = 2'd1,
        M_ERASE = 2'd2
    } mode_t;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/isp_ram.sv
module isp_ram #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          clr,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/isp_target.sv
module isp_target #(
    parameter int CODE_AW      = 10,
    parameter int DATA_AW      = 8,
    parameter int WRITE_CYCLES = 200,
    parameter int ERASE_CYCLES = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_hold,
    input  logic lock,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    import isp_pkg::*;

    localparam int MAXC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          sck_p;
        logic [4:0]    cnt;
        logic [30:0]   sr;
        logic          en;
        logic [7:0]    rd_op;
        logic [15:0]   rd_addr;
        logic [7:0]    out;
        mode_t         mode;
        logic [TW-1:0] timer;
        logic          wr_space;
        logic [15:0]   wr_addr;
        logic [7:0]    wr_data;
    } st_t;

    st_t q, d;

    logic [3:0] sync_q;
    logic       sck_s, mosi_s, hold_s, lock_s, act;

    isp_sync #(.W(4)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sck, mosi, prog_hold, lock}),
        .q    (sync_q)
    );

    assign {sck_s, mosi_s, hold_s, lock_s} = sync_q;
    assign act = hold_s & ~lock_s;

    // Store interfaces
    logic       we_code, we_data, clr_all;
    logic [7:0] code_rdata, data_rdata;

    assign we_code = (q.mode == M_WRITE) && (q.timer == TW'(1)) && !q.wr_space;
    assign we_data = (q.mode == M_WRITE) && (q.timer == TW'(1)) &&  q.wr_space;
    assign clr_all = (q.mode == M_ERASE) && (q.timer == TW'(1));

    isp_ram #(.AW(CODE_AW)) u_code (
        .clk  (clk),
        .we   (we_code),
        .waddr(q.wr_addr[CODE_AW-1:0]),
        .wdata(q.wr_data),
        .clr  (clr_all),
        .raddr(q.rd_addr[CODE_AW-1:0]),
        .rdata(code_rdata)
    );

    isp_ram #(.AW(DATA_AW)) u_data (
        .clk  (clk),
        .we   (we_data),
        .waddr(q.wr_addr[DATA_AW-1:0]),
        .wdata(q.wr_data),
        .clr  (clr_all),
        .raddr(q.rd_addr[DATA_AW-1:0]),
        .rdata(data_rdata)
    );

    // Read value for the data phase
    logic       rd_is_read, rd_space, poll_hit;
    logic [7:0] rd_val;

    assign rd_is_read = (q.rd_op == OPC_RD_CODE) || (q.rd_op == OPC_RD_DATA);
    assign rd_space   = (q.rd_op == OPC_RD_DATA);
    assign poll_hit   = (q.mode == M_WRITE) && (q.wr_space == rd_space) && (q.wr_addr == q.rd_addr);

    always_comb begin
        if (!q.en || !rd_is_read || q.mode == M_ERASE) rd_val = 8'h00;
        else if (poll_hit)                             rd_val = q.wr_data ^ 8'h80;
        else if (rd_space)                             rd_val = data_rdata;
        else                                           rd_val = code_rdata;
    end

    // Next-state logic
    logic       rise, fall;
    logic [7:0] f_op;

    assign rise = sck_s & ~q.sck_p;
    assign fall = ~sck_s & q.sck_p;
    assign f_op = q.sr[30:23];

    always_comb begin
        d       = q;
        d.sck_p = sck_s;

        if (q.mode != M_IDLE) begin
            if (q.timer == TW'(1)) d.mode  = M_IDLE;
            else                   d.timer = q.timer - TW'(1);
        end

        if (!act) begin
            d.cnt = '0;
            d.en  = 1'b0;
            d.out = '0;
        end else begin
            if (rise) begin
                d.sr  = {q.sr[29:0], mosi_s};
                d.cnt = q.cnt + 5'd1;
                if (q.cnt == 5'd23) begin
                    d.rd_op   = q.sr[22:15];
                    d.rd_addr = {q.sr[14:0], mosi_s};
                end
                if (q.cnt == 5'd31) begin
                    if (f_op == OPC_ENABLE) begin
                        d.en = 1'b1;
                    end else if (q.en && q.mode == M_IDLE) begin
                        if (f_op == OPC_ERASE) begin
                            d.mode  = M_ERASE;
                            d.timer = TW'(ERASE_CYCLES);
                        end else if (f_op == OPC_WR_CODE || f_op == OPC_WR_DATA) begin
                            d.mode     = M_WRITE;
                            d.timer    = TW'(WRITE_CYCLES);
                            d.wr_space = (f_op == OPC_WR_DATA);
                            d.wr_addr  = q.sr[22:7];
                            d.wr_data  = {q.sr[6:0], mosi_s};
                        end
                    end
                end
            end
            if (fall) begin
                if (q.cnt == 5'd24)      d.out = rd_val;
                else if (q.cnt > 5'd24)  d.out = {q.out[6:0], 1'b0};
                else                     d.out = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso = q.out[7];

    // Named views for the bound checker
    logic          en_q, busy_q;
    logic [TW-1:0] timer_q;
    logic [15:0]   wr_addr_q;
    logic [7:0]    wr_data_q;

    assign en_q      = q.en;
    assign busy_q    = (q.mode != M_IDLE);
    assign timer_q   = q.timer;
    assign wr_addr_q = q.wr_addr;
    assign wr_data_q = q.wr_data;
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          miso,
    input logic          lock_s,
    input logic          hold_s,
    input logic          en_q,
    input logic          busy_q,
    input logic [TW-1:0] timer_q,
    input logic [15:0]   wr_addr_q,
    input logic [7:0]    wr_data_q,
    input logic          we_code,
    input logic          we_data,
    input logic          clr_all
);
    assert_lock_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_s |=> !miso);

    assert_hold_drops_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> !en_q);

    assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(en_q));

    assert_busy_holds_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && timer_q > TW'(1)) |=> ($stable(wr_addr_q) && $stable(wr_data_q) && busy_q));

    assert_timer_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && timer_q > TW'(1)) |=> (timer_q == $past(timer_q) - TW'(1)));

    assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_code, we_data, clr_all}));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!miso && !busy_q && !en_q));
endmodule

bind isp_target isp_target_chk #(.TW(TW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .miso     (miso),
    .lock_s   (lock_s),
    .hold_s   (hold_s),
    .en_q     (en_q),
    .busy_q   (busy_q),
    .timer_q  (timer_q),
    .wr_addr_q(wr_addr_q),
    .wr_data_q(wr_data_q),
    .we_code  (we_code),
    .we_data  (we_data),
    .clr_all  (clr_all)
);

// File: tb/sim_isp_target.sv
module sim_isp_target;
    localparam int WC   = 4000;
    localparam int EC   = 8000;
    localparam int HALF = 25;

    logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, lock = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso;

    always #5 clk = ~clk;

    isp_target #(.WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_hold(hold), .lock(lock),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    int      checks = 0, errors = 0, bad_idle = 0;
    longint  cyc = 0;
    bit      phase = 0, watch_on = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // R11: MISO must be low outside a read data phase, checked each clock
    always @(negedge clk) if (watch_on && !phase && miso !== 1'b0) bad_idle++;

    // Behavioural reference model
    logic [7:0] cmem [int];
    logic [7:0] dmem [int];
    bit         m_en = 0;
    int         p_kind = 0;   // 0 idle, 1 write, 2 erase
    bit         p_space;
    int         p_addr;
    logic [7:0] p_data;
    longint     p_end;

    function automatic void apply();
        if (p_kind != 0 && cyc >= p_end) begin
            if (p_kind == 1) begin
                if (p_space) dmem[p_addr] = p_data;
                else         cmem[p_addr] = p_data;
            end else begin
                cmem.delete();
                dmem.delete();
            end
            p_kind = 0;
        end
    endfunction

    function automatic logic [7:0] mget(bit sp, int a);
        if (sp) return dmem.exists(a) ? dmem[a] : 8'hFF;
        return cmem.exists(a) ? cmem[a] : 8'hFF;
    endfunction

    function automatic logic [7:0] expect_rd(logic [7:0] op, int a);
        bit sp;
        apply();
        sp = (op == 8'h28);
        if (!m_en || !(hold && !lock)) return 8'h00;
        if (op != 8'h20 && op != 8'h28) return 8'h00;
        if (p_kind == 2) return 8'h00;
        if (p_kind == 1 && p_space == sp && p_addr == a) return p_data ^ 8'h80;
        return mget(sp, a);
    endfunction

    function automatic void model_frame(logic [7:0] op, int a, logic [7:0] dv);
        apply();
        if (!(hold && !lock)) return;
        if (op == 8'hA5) m_en = 1;
        else if (m_en && p_kind == 0) begin
            if (op == 8'hC3) begin
                p_kind = 2; p_end = cyc + EC;
            end else if (op == 8'h40 || op == 8'h48) begin
                p_kind = 1; p_end = cyc + WC;
                p_space = (op == 8'h48); p_addr = a; p_data = dv;
            end
        end
    endfunction

    task automatic xfer(input logic [7:0] op, input int a, input logic [7:0] dv,
                        output logic [7:0] rd, output logic [7:0] ex);
        logic [31:0] fr;
        fr = {op, a[15:0], dv};
        rd = 8'h00;
        ex = 8'h00;
        for (int i = 0; i < 32; i++) begin
            mosi = fr[31-i];
            repeat (HALF) @(negedge clk);
            if (i >= 24) rd[31-i] = miso;
            sck = 1'b1;
            if (i == 31) model_frame(op, a, dv);
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            if (i == 23) begin
                phase = 1;
                ex = expect_rd(op, a);
            end
        end
        repeat (6) @(negedge clk);
        phase = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] op, input int a, input logic [7:0] dv);
        logic [7:0] r, e;
        xfer(op, a, dv, r, e);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] op, input int a);
        logic [7:0] r, e;
        xfer(op, a, 8'h00, r, e);
        checks++;
        if (r !== e) begin
            errors++;
            $display("FAIL %s op=%02h addr=%0d actual=%02h expected=%02h", tag, op, a, r, e);
        end
    endtask

    task automatic set_hold(input logic v);
        hold = v;
        if (!v) m_en = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic set_lock(input logic v);
        lock = v;
        if (v) m_en = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        checks++;
        if (miso !== 1'b0) begin
            errors++;
            $display("FAIL R1 miso during reset actual=%b expected=0", miso);
        end
        rst_n = 1'b1;
        idle(5);
        watch_on = 1;
        checks++;
        if (miso !== 1'b0) begin
            errors++;
            $display("FAIL R1 miso after reset actual=%b expected=0", miso);
        end
        set_hold(1);

        // R2: read before enable gives 00
        rd_chk("R2 read before enable", 8'h20, 0);

        // R6: erase, reads during and after
        send(8'hA5, 0, 8'h00);
        send(8'hC3, 0, 8'h00);
        rd_chk("R6 read during erase", 8'h20, 3);
        idle(EC + 1000);
        rd_chk("R6 code after erase", 8'h20, 3);
        rd_chk("R6 data after erase", 8'h28, 3);

        // R9/R2: dropping hold clears enable; write without enable ignored
        set_hold(0);
        set_hold(1);
        send(8'h40, 5, 8'h12);
        rd_chk("R2 read after hold cycle no enable", 8'h20, 5);
        send(8'hA5, 0, 8'h00);
        idle(WC + 500);
        rd_chk("R9 write without re-enable ignored", 8'h20, 5);

        // R5/R3/R4: write, poll, neighbour, final
        send(8'h40, 7, 8'h3C);
        rd_chk("R5 poll code bit7 clear", 8'h20, 7);
        rd_chk("R5 neighbour during write", 8'h20, 8);
        idle(WC + 500);
        rd_chk("R3 R4 code after write", 8'h20, 7);

        // R5/R7: data store, bit7 set
        send(8'h48, 7, 8'hA5);
        rd_chk("R5 poll data bit7 set", 8'h28, 7);
        idle(WC + 500);
        rd_chk("R7 data store value", 8'h28, 7);
        rd_chk("R7 code store untouched", 8'h20, 7);

        // R8: write during write ignored; R3 overwrite without erase
        send(8'h40, 9, 8'h81);
        send(8'h40, 10, 8'h55);
        idle(WC + 500);
        rd_chk("R8 second write ignored", 8'h20, 10);
        rd_chk("R3 first write stored", 8'h20, 9);
        send(8'h40, 9, 8'h7E);
        idle(WC + 500);
        rd_chk("R3 overwrite replaces value", 8'h20, 9);

        // R10: lock blocks everything
        set_lock(1);
        send(8'hA5, 0, 8'h00);
        send(8'h48, 1, 8'h00);
        rd_chk("R10 read while locked", 8'h28, 7);
        set_lock(0);
        idle(WC + 500);
        rd_chk("R10 enable cleared by lock", 8'h28, 1);
        send(8'hA5, 0, 8'h00);
        rd_chk("R10 locked write ignored", 8'h28, 1);

        // R8: write during erase ignored
        send(8'hC3, 0, 8'h00);
        send(8'h40, 9, 8'h11);
        rd_chk("R6 data read during erase", 8'h28, 7);
        idle(EC + 1000);
        rd_chk("R8 write during erase ignored", 8'h20, 9);
        rd_chk("R6 data erased", 8'h28, 7);

        // R11: idle MISO across the whole run
        checks++;
        if (bad_idle != 0) begin
            errors++;
            $display("FAIL R11 miso high outside data phase actual=%0d expected=0", bad_idle);
        end
        summary();
    end
endmodule